// File: doc/BRIEF.md
# Descriptor Staging and Commit Queue

This block is the slave-side landing zone for transfer descriptors aimed at a scatter-gather copy engine. Software writes the eight 32-bit words of one descriptor into a small word-addressed window. Each word lands in a staging register. Writing the last word, the control word, with its commit bit set copies the staged words and the new control value into a descriptor queue as one entry. A half-written descriptor can therefore never reach the engine.

The queue reports whether it is full or empty and how many entries it holds, so a status block can expose them. Software is expected to check the full flag before it commits. If a commit arrives while the queue is full, the block drops that commit and raises a sticky overflow flag. The staged words stay as they were, so rewriting only the control word retries the same descriptor. On the far side, committed descriptors leave in arrival order over a valid/ready handshake toward the downstream engine.

Top module: `desc_commit_buf`

## Requirements
- R1: After reset the queue is empty: `fifo_empty`=1, `fifo_full`=0, `fill_level`=0, `dsc_valid`=0 and `ovf_flag`=0.
- R2: A write to word index 0 to 6 (`wr_word`) only updates that staging word. It leaves `fill_level`, `dsc_valid` and `dsc_data` unchanged.
- R3: A write to word index 7 with `wr_data[31]`=0 adds no entry and leaves `fill_level` unchanged.
- R4: A write to word index 7 with `wr_data[31]`=1 while the queue is not full adds exactly one entry, visible on the following cycle. The entry holds staged word i in `dsc_data[32*i+31:32*i]` for i=0..6 and the written control value in `dsc_data[255:224]`.
- R5: Entries leave in the order they were committed.
- R6: An entry is removed on a clock edge where `dsc_valid` and `dsc_ready` are both 1. While `dsc_valid`=1 and `dsc_ready`=0, `dsc_data` holds steady.
- R7: `fill_level` equals the number of stored entries, zero-extended to 16 bits. `fifo_full`=1 exactly when it equals DEPTH (default 16), and `fifo_empty`=1 exactly when it is 0.
- R8: A commit write while `fifo_full`=1 adds no entry and sets `ovf_flag`. Once set, `ovf_flag` stays at 1 until reset.
- R9: Staged words keep their values after a commit and after a dropped commit. A later control-only commit therefore enqueues the previously staged words 0 to 6.
- R10: A commit and a pop on the same edge leave `fill_level` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the descriptor window |
| wr_word | input | 3 | Word index within the descriptor (7 = control) |
| wr_data | input | 32 | Write data; bit 31 of the control word commits |
| dsc_valid | output | 1 | Head entry is available |
| dsc_ready | input | 1 | Downstream accepts the head entry |
| dsc_data | output | 256 | Head descriptor, word i at bits 32*i+31:32*i |
| fifo_full | output | 1 | Queue holds DEPTH entries |
| fifo_empty | output | 1 | Queue holds no entry |
| fill_level | output | 16 | Number of stored entries |
| ovf_flag | output | 1 | Sticky: a commit was dropped because the queue was full |

## Verification
The properties take the write strobe, word index and data as driven once per cycle. They also assume `dsc_ready` is a plain level that may be high while the queue is empty, and they make no assumption about when software checks the full flag. Because of that, the stimulus deliberately commits into a full queue and raises ready on an empty one. Within those rules, the level-change properties cover every combination of commit, non-commit write and pop. The bench predicts queue contents with its own ordered model built from the staged words.

// File: rtl/desc_commit_pkg.sv
package desc_commit_pkg;
   localparam int unsigned WORD_W    = 32;
   localparam int unsigned DSC_WORDS = 8;
   localparam int unsigned IDX_W     = $clog2(DSC_WORDS);
   localparam int unsigned CTRL_IDX  = DSC_WORDS - 1;
   localparam int unsigned COMMIT_BIT = 31;
   localparam int unsigned DSC_W     = WORD_W * DSC_WORDS;

   typedef logic [WORD_W-1:0] word_t;
   typedef logic [DSC_W-1:0]  dsc_t;

   // control word layout, bit 31 commits
   typedef struct packed {
      logic       commit;
      logic [5:0] rsvd;
      logic       early_done;
      logic [7:0] err_irq_mask;
      logic       early_irq;
      logic       done_irq;
      logic       stop_on_len;
      logic       stop_on_eop;
      logic       hold_wr_addr;
      logic       hold_rd_addr;
      logic       mark_eop;
      logic       mark_sop;
      logic [7:0] channel;
   } ctrl_t;

   function automatic logic is_commit(input logic [IDX_W-1:0] idx, input word_t data);
      ctrl_t c;
      c = ctrl_t'(data);
      return (idx == IDX_W'(CTRL_IDX)) && c.commit;
   endfunction
endpackage

// File: rtl/desc_stage_regs.sv
module desc_stage_regs
   import desc_commit_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  word_t            wr_data,
   output logic [WORD_W*(DSC_WORDS-1)-1:0] staged
);
   localparam int unsigned BODY_WORDS = DSC_WORDS - 1;

   for (genvar i = 0; i < BODY_WORDS; i++) begin : g_word
      word_t q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= '0;
         else if (wr_en && (wr_idx == IDX_W'(i)))
            q <= wr_data;
      end
      assign staged[i*WORD_W +: WORD_W] = q;
   end
endmodule

// File: rtl/desc_commit_ctrl.sv
module desc_commit_ctrl
   import desc_commit_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  word_t            wr_data,
   input  logic             q_full,
   output logic             push,
   output logic             ovf
);
   logic go;
   logic drop;

   always_comb begin
      go   = wr_en && is_commit(wr_idx, wr_data);
      push = go && !q_full;
      drop = go && q_full;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ovf <= 1'b0;
      else if (drop)
         ovf <= 1'b1;
   end
endmodule

// File: rtl/desc_fifo.sv
module desc_fifo #(
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned DATA_W = 256,
   parameter int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              full,
   output logic              empty,
   output logic [CNT_W-1:0]  count
);
   localparam int unsigned PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit          POW2    = (DEPTH == (1 << PTR_W));
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic              pop;

   assign pop = out_valid && out_ready;

   if (POW2) begin : g_wrap_free
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (push)
         mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         unique case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign empty     = (count == '0);
   assign full      = (count == CNT_W'(DEPTH));
   assign out_valid = !empty;
   assign out_data  = mem[rd_ptr];
endmodule

// File: rtl/desc_commit_buf.sv
module desc_commit_buf
   import desc_commit_pkg::*;
#(
   parameter int unsigned DEPTH   = 16,
   parameter int unsigned LEVEL_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_word,
   input  logic [WORD_W-1:0] wr_data,
   output logic             dsc_valid,
   input  logic             dsc_ready,
   output logic [DSC_W-1:0] dsc_data,
   output logic             fifo_full,
   output logic             fifo_empty,
   output logic [LEVEL_W-1:0] fill_level,
   output logic             ovf_flag
);
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   initial begin
      if (DEPTH < 2)
         $fatal(1, "desc_commit_buf: DEPTH must be at least 2");
      if (CNT_W > LEVEL_W)
         $fatal(1, "desc_commit_buf: LEVEL_W too narrow for DEPTH");
      if (WORD_W != 32 || DSC_WORDS != 8)
         $fatal(1, "desc_commit_buf: descriptor shape is fixed at 8x32");
   end

   logic [WORD_W*(DSC_WORDS-1)-1:0] staged;
   logic                            push;
   logic [CNT_W-1:0]                count;
   dsc_t                            entry;

   desc_stage_regs u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_word),
      .wr_data (wr_data),
      .staged  (staged)
   );

   desc_commit_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_word),
      .wr_data (wr_data),
      .q_full  (fifo_full),
      .push    (push),
      .ovf     (ovf_flag)
   );

   assign entry = {wr_data, staged};

   desc_fifo #(
      .DEPTH  (DEPTH),
      .DATA_W (DSC_W),
      .CNT_W  (CNT_W)
   ) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_data (entry),
      .out_ready (dsc_ready),
      .out_valid (dsc_valid),
      .out_data  (dsc_data),
      .full      (fifo_full),
      .empty     (fifo_empty),
      .count     (count)
   );

   assign fill_level = LEVEL_W'(count);
endmodule

// File: rtl/desc_commit_buf_chk.sv
module desc_commit_buf_chk
   import desc_commit_pkg::*;
#(
   parameter int unsigned DEPTH   = 16,
   parameter int unsigned LEVEL_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [IDX_W-1:0] wr_word,
   input logic [WORD_W-1:0] wr_data,
   input logic             dsc_valid,
   input logic             dsc_ready,
   input logic [DSC_W-1:0] dsc_data,
   input logic             fifo_full,
   input logic             fifo_empty,
   input logic [LEVEL_W-1:0] fill_level,
   input logic             ovf_flag
);
   logic go_w, pop_w, other_w;
   assign go_w    = wr_en && (wr_word == IDX_W'(CTRL_IDX)) && wr_data[COMMIT_BIT];
   assign pop_w   = dsc_valid && dsc_ready;
   assign other_w = !go_w;

   p_no_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (other_w && !pop_w) |=> $stable(fill_level));

   p_push_grow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (go_w && !fifo_full && !pop_w) |=> (fill_level == $past(fill_level) + 1'b1));

   p_pop_shrink_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_w && !go_w) |=> (fill_level == $past(fill_level) - 1'b1));

   p_hold_head_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dsc_valid && !dsc_ready) |=> (dsc_valid && $stable(dsc_data)));

   p_level_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fill_level <= LEVEL_W'(DEPTH));

   p_drop_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (go_w && fifo_full) |=> (ovf_flag && fill_level <= $past(fill_level)));

   p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_flag |=> ovf_flag);

   p_both_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (go_w && !fifo_full && pop_w) |=> $stable(fill_level));
endmodule

bind desc_commit_buf desc_commit_buf_chk #(
   .DEPTH   (DEPTH),
   .LEVEL_W (LEVEL_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_word    (wr_word),
   .wr_data    (wr_data),
   .dsc_valid  (dsc_valid),
   .dsc_ready  (dsc_ready),
   .dsc_data   (dsc_data),
   .fifo_full  (fifo_full),
   .fifo_empty (fifo_empty),
   .fill_level (fill_level),
   .ovf_flag   (ovf_flag)
);

// File: tb/desc_commit_buf_tb_top.sv
module desc_commit_buf_tb_top;
   localparam int DEPTH = 16;
   localparam int NV    = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [2:0]   wr_word = '0;
   logic [31:0]  wr_data = '0;
   logic         dsc_ready = 1'b0;
   logic         dsc_valid;
   logic [255:0] dsc_data;
   logic         fifo_full, fifo_empty, ovf_flag;
   logic [15:0]  fill_level;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   logic [255:0] mq[$];

   always #2 clk = ~clk;

   desc_commit_buf #(.DEPTH(DEPTH), .LEVEL_W(16)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
      .wr_data(wr_data), .dsc_valid(dsc_valid), .dsc_ready(dsc_ready),
      .dsc_data(dsc_data), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
      .fill_level(fill_level), .ovf_flag(ovf_flag)
   );

   // {wr_en, word, data, ready, expected level}
   localparam logic [44:0] VEC [NV] = '{
      {1'b1, 3'd0, 32'h1111_1111, 1'b0, 8'd0},   // R2
      {1'b1, 3'd3, 32'hABCD_0000, 1'b0, 8'd0},   // R2
      {1'b1, 3'd7, 32'h0000_0F00, 1'b0, 8'd0},   // R3
      {1'b1, 3'd7, 32'h8000_0300, 1'b0, 8'd1},   // R4
      {1'b1, 3'd7, 32'h8000_0301, 1'b0, 8'd2},   // R4
      {1'b0, 3'd0, 32'h0000_0000, 1'b1, 8'd1},   // R6
      {1'b1, 3'd7, 32'h8000_0302, 1'b1, 8'd1},   // R10
      {1'b1, 3'd5, 32'h5555_5555, 1'b1, 8'd0},   // R2 with pop
      {1'b0, 3'd0, 32'h0000_0000, 1'b1, 8'd0},   // R6 ready on empty
      {1'b1, 3'd7, 32'h8000_0303, 1'b0, 8'd1}    // R4
   };

   task automatic chk(input string rq, input logic [255:0] act, input logic [255:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   function automatic logic [255:0] desc_of(input logic [31:0] base, input logic [31:0] ctrl);
      logic [255:0] d;
      for (int i = 0; i < 7; i++) d[i*32 +: 32] = base + 32'(i);
      d[224 +: 32] = ctrl;
      return d;
   endfunction

   task automatic write_word(input logic [2:0] idx, input logic [31:0] data);
      wr_en = 1'b1; wr_word = idx; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic load_desc(input logic [31:0] base, input logic [31:0] ctrl);
      for (int i = 0; i < 7; i++) write_word(3'(i), base + 32'(i));
      write_word(3'd7, ctrl);
   endtask

   task automatic pop_check(input string rq, input logic [255:0] exp);
      chk(rq, {255'd0, dsc_valid}, 256'd1);
      chk(rq, dsc_data, exp);
      dsc_ready = 1'b1;
      @(negedge clk);
      dsc_ready = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1", {252'd0, fifo_empty, fifo_full, dsc_valid, ovf_flag}, {252'd0, 4'b1000});
      chk("R1", 256'(fill_level), 256'd0);

      // table walk
      for (int v = 0; v < NV; v++) begin
         wr_en = VEC[v][44]; wr_word = VEC[v][43:41]; wr_data = VEC[v][40:9];
         dsc_ready = VEC[v][8];
         @(negedge clk);
         wr_en = 1'b0; dsc_ready = 1'b0;
         chk($sformatf("R2/R3/R4/R6/R10 vec%0d", v), 256'(fill_level), 256'(VEC[v][7:0]));
      end
      dsc_ready = 1'b1;
      @(negedge clk);
      dsc_ready = 1'b0;
      chk("R7 empty", {255'd0, fifo_empty}, 256'd1);

      // R4/R5 order and content
      for (int k = 0; k < 3; k++) begin
         load_desc(32'h2000_0000 + 32'(k * 256), 32'h8000_4300 | 32'(k));
         mq.push_back(desc_of(32'h2000_0000 + 32'(k * 256), 32'h8000_4300 | 32'(k)));
      end
      chk("R4 level", 256'(fill_level), 256'd3);
      // R2 non-control write leaves head intact
      write_word(3'd1, 32'hDEAD_BEEF);
      chk("R2 level", 256'(fill_level), 256'd3);
      while (mq.size() > 0) pop_check("R5", mq.pop_front());

      // fill to full
      for (int k = 0; k < DEPTH; k++) begin
         load_desc(32'h3000_0000 + 32'(k * 16), 32'h8000_0000 | 32'(k));
         mq.push_back(desc_of(32'h3000_0000 + 32'(k * 16), 32'h8000_0000 | 32'(k)));
      end
      chk("R7 full", {254'd0, fifo_full, fifo_empty}, 256'b10);
      chk("R7 level", 256'(fill_level), 256'(DEPTH));
      chk("R8 before", {255'd0, ovf_flag}, 256'd0);
      write_word(3'd7, 32'h8000_00FF);
      chk("R8 drop level", 256'(fill_level), 256'(DEPTH));
      chk("R8 flag", {255'd0, ovf_flag}, 256'd1);
      pop_check("R6 head after drop", mq.pop_front());
      chk("R6 level", 256'(fill_level), 256'(DEPTH - 1));
      // R9 retry with control only
      write_word(3'd7, 32'h8000_00EE);
      mq.push_back(desc_of(32'h3000_0000 + 32'((DEPTH - 1) * 16), 32'h8000_00EE));
      chk("R9 level", 256'(fill_level), 256'(DEPTH));
      while (mq.size() > 0) pop_check("R5/R9", mq.pop_front());
      chk("R7 drained", {254'd0, fifo_empty, dsc_valid}, 256'b10);
      chk("R7 level0", 256'(fill_level), 256'd0);
      chk("R8 sticky", {255'd0, ovf_flag}, 256'd1);

      // reset clears everything
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      chk("R1 rereset", {252'd0, fifo_empty, fifo_full, dsc_valid, ovf_flag}, {252'd0, 4'b1000});

      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule